// File: doc/BRIEF.md
# Branch Delay-Slot Hazard Controller

This block steers stalls and flushes for an in-order, seven-stage processor pipeline. The pipeline has one architectural branch delay slot and predicts every branch not-taken. The block keeps a shadow copy of what each stage holds: an occupancy bit, a branch bit and a delay-slot bit. It advances that copy in step with the datapath. Each cycle it uses the copy, per-stage read-after-write stall requests and the taken flag from the resolution stage to produce per-stage stall, squash and bubble signals and a fetch redirect.

Stage 0 is fetch, stage 1 is decode and stage 4 (parameter `RES_STG`) is where branches resolve. Bit `s` of every per-stage vector refers to stage `s`, and a higher index means an older instruction. A data-hazard stall can open a bubble between a branch and its delay slot. The block therefore tags the delay slot when it is fetched, not by where it sits, and so finds the true slot in any layout. A branch that reaches decode while an earlier delay slot has not yet passed the resolution stage is held in decode. At most one delay slot is ever unresolved.

A small fetch-side state machine records whether the next accepted instruction is owed the delay-slot tag. Its state `FS_SEQ` means no slot is owed. Its state `FS_SLOT_DUE` means the last accepted instruction was a branch. An accepted branch moves `FS_SEQ` to `FS_SLOT_DUE`. Any accepted non-branch moves the machine back to `FS_SEQ`. With no accepted fetch, the machine keeps its state.

Top module: `slot_hazard_ctrl`

## Requirements
- R1: While reset is active and on leaving it, every stage is unoccupied, the fetch state is `FS_SEQ`, and with idle inputs all stall, squash, bubble and redirect outputs are 0.
- R2: When stage 0 is not stalled, the fetch input enters stage 0 unless it is killed. It carries its branch flag, and it gets the delay-slot tag exactly when the previously accepted instruction was a branch. Bubbles carry no tags, and a tag moves with its instruction.
- R3: Let `h` be the oldest stage with a stall request. Then `stage_stall` is 1 for stages 0..`h` and those stages hold their contents. `stage_bubble` is one-hot at `h+1` when `h+1` < 7, and that stage becomes empty. Stages older than `h+1` advance.
- R4: A `raw_req` bit for an unoccupied stage has no effect.
- R5: An occupied branch in stage 1 raises a stall request at stage 1 while any of stages 2..4 holds a delay-slot tag.
- R6: `fetch_redirect` is 1 exactly when stage 4 holds an occupied branch, `res_taken` is 1 and stage 4 is not stalled.
- R7: In a redirect cycle, every occupied stage below 4 without the delay-slot tag gets `stage_squash` and is empty in the next cycle. The delay slot is kept, and no squash occurs without a redirect.
- R8: In a redirect cycle, an accepted fetch is discarded unless the state is `FS_SLOT_DUE`, in which case it enters as the delay slot.
- R9: A taken branch in stage 4 whose stage is stalled by an older or equal request gives no redirect until the stall clears.
- R10: `res_taken` has no effect when stage 4 does not hold an occupied branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetched instruction is offered to stage 0 |
| fetch_branch | input | 1 | The offered instruction is a branch or jump |
| raw_req | input | 7 | Per-stage read-after-write stall request |
| res_taken | input | 1 | The branch in the resolution stage is taken |
| stage_stall | output | 7 | Per-stage hold |
| stage_squash | output | 7 | Per-stage flush to a bubble |
| stage_bubble | output | 7 | Per-stage bubble insertion |
| fetch_redirect | output | 1 | Steer fetch to the branch target |
| occ_valid | output | 7 | Stage holds a real instruction |
| occ_branch | output | 7 | Stage holds a branch |
| occ_slot | output | 7 | Stage holds a delay slot |

## Verification
The bench drives long pseudo-random streams at several stall densities and compares every output against an arithmetic model each cycle. That pressure targets a delay slot separated from its branch by a bubble. A design that tagged the slot by position would squash it there, and the squash vector would show it. The bench also aims at a taken branch frozen by an older stall, where an early redirect would fire while stage 4 is held, and at a second branch reaching decode while a slot is unresolved, where a missing guard stall would show up at stage 1. It also covers a fetch arriving in a redirect cycle: discarding an owed slot, or keeping a wrong-path instruction, would show up in the stage 0 occupancy one cycle later.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic {
        FS_SEQ      = 1'b0,
        FS_SLOT_DUE = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/hzd_stall_arb.sv
module hzd_stall_arb #(
    parameter int NSTG    = 7,
    parameter int DEC_STG = 1,
    parameter int RES_STG = 4
) (
    input  logic [NSTG-1:0] raw_req,
    input  logic [NSTG-1:0] v,
    input  logic [NSTG-1:0] b,
    input  logic [NSTG-1:0] d,
    output logic [NSTG-1:0] stall,
    output logic [NSTG-1:0] bubble
);
    localparam int IW = $clog2(NSTG);

    logic            guard;
    logic [NSTG-1:0] req;
    logic            any_req;
    logic [IW-1:0]   hi;

    // a branch in decode waits while an earlier delay slot is unresolved
    assign guard = v[DEC_STG] & b[DEC_STG] & (|d[RES_STG:DEC_STG+1]);

    always_comb begin
        req = raw_req & v;
        req[DEC_STG] = req[DEC_STG] | guard;
    end

    always_comb begin
        any_req = 1'b0;
        hi      = '0;
        for (int s = 0; s < NSTG; s++) begin
            if (req[s]) begin
                any_req = 1'b1;
                hi      = IW'(s);
            end
        end
    end

    always_comb begin
        for (int s = 0; s < NSTG; s++) begin
            stall[s]  = any_req && (s <= int'(hi));
            bubble[s] = any_req && (s == int'(hi) + 1);
        end
    end
endmodule

// File: rtl/hzd_resolve.sv
module hzd_resolve #(
    parameter int NSTG    = 7,
    parameter int RES_STG = 4
) (
    input  logic [NSTG-1:0] v,
    input  logic [NSTG-1:0] b,
    input  logic [NSTG-1:0] d,
    input  logic [NSTG-1:0] stall,
    input  logic            res_taken,
    output logic            fire,
    output logic [NSTG-1:0] squash
);
    assign fire = v[RES_STG] & b[RES_STG] & res_taken & ~stall[RES_STG];

    always_comb begin
        for (int s = 0; s < NSTG; s++) begin
            if (s < RES_STG) squash[s] = fire & v[s] & ~d[s];
            else             squash[s] = 1'b0;
        end
    end
endmodule

// File: rtl/hzd_fetch_fsm.sv
module hzd_fetch_fsm
    import hzd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic fetch_valid,
    input  logic fetch_branch,
    input  logic fire,
    output logic take,
    output logic slot_due
);
    fetch_state_e state, state_nx;
    logic         kill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_SEQ;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        slot_due = 1'b0;
        unique case (state)
            FS_SEQ: begin
                slot_due = 1'b0;
            end
            FS_SLOT_DUE: begin
                slot_due = 1'b1;
            end
        endcase
        kill = fire & ~slot_due;
        take = accept & fetch_valid & ~kill;
        if (take) state_nx = fetch_branch ? FS_SLOT_DUE : FS_SEQ;
    end
endmodule

// File: rtl/hzd_tag_pipe.sv
module hzd_tag_pipe #(
    parameter int NSTG = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTG-1:0] stall,
    input  logic [NSTG-1:0] bubble,
    input  logic [NSTG-1:0] squash,
    input  logic            take,
    input  logic            fetch_branch,
    input  logic            slot_due,
    output logic [NSTG-1:0] v,
    output logic [NSTG-1:0] b,
    output logic [NSTG-1:0] d
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v <= '0;
            b <= '0;
            d <= '0;
        end else begin
            for (int s = 1; s < NSTG; s++) begin
                if (stall[s]) begin
                    v[s] <= v[s] & ~squash[s];
                    b[s] <= b[s] & ~squash[s];
                end else if (bubble[s]) begin
                    v[s] <= 1'b0;
                    b[s] <= 1'b0;
                    d[s] <= 1'b0;
                end else begin
                    v[s] <= v[s-1] & ~squash[s-1];
                    b[s] <= b[s-1] & ~squash[s-1];
                    d[s] <= d[s-1];
                end
            end
            if (stall[0]) begin
                v[0] <= v[0] & ~squash[0];
                b[0] <= b[0] & ~squash[0];
            end else begin
                v[0] <= take;
                b[0] <= take & fetch_branch;
                d[0] <= take & slot_due;
            end
        end
    end
endmodule

// File: rtl/slot_hazard_ctrl.sv
module slot_hazard_ctrl #(
    parameter int NSTG    = 7,
    parameter int DEC_STG = 1,
    parameter int RES_STG = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic            fetch_branch,
    input  logic [NSTG-1:0] raw_req,
    input  logic            res_taken,
    output logic [NSTG-1:0] stage_stall,
    output logic [NSTG-1:0] stage_squash,
    output logic [NSTG-1:0] stage_bubble,
    output logic            fetch_redirect,
    output logic [NSTG-1:0] occ_valid,
    output logic [NSTG-1:0] occ_branch,
    output logic [NSTG-1:0] occ_slot
);
    logic [NSTG-1:0] v, b, d;
    logic [NSTG-1:0] stall, bubble, squash;
    logic            fire, take, slot_due;

    hzd_stall_arb #(.NSTG(NSTG), .DEC_STG(DEC_STG), .RES_STG(RES_STG)) u_arb (
        .raw_req (raw_req),
        .v       (v),
        .b       (b),
        .d       (d),
        .stall   (stall),
        .bubble  (bubble)
    );

    hzd_resolve #(.NSTG(NSTG), .RES_STG(RES_STG)) u_res (
        .v         (v),
        .b         (b),
        .d         (d),
        .stall     (stall),
        .res_taken (res_taken),
        .fire      (fire),
        .squash    (squash)
    );

    hzd_fetch_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (~stall[0]),
        .fetch_valid  (fetch_valid),
        .fetch_branch (fetch_branch),
        .fire         (fire),
        .take         (take),
        .slot_due     (slot_due)
    );

    hzd_tag_pipe #(.NSTG(NSTG)) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall        (stall),
        .bubble       (bubble),
        .squash       (squash),
        .take         (take),
        .fetch_branch (fetch_branch),
        .slot_due     (slot_due),
        .v            (v),
        .b            (b),
        .d            (d)
    );

    assign stage_stall    = stall;
    assign stage_squash   = squash;
    assign stage_bubble   = bubble;
    assign fetch_redirect = fire;
    assign occ_valid      = v;
    assign occ_branch     = b;
    assign occ_slot       = d;
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
    parameter int NSTG    = 7,
    parameter int DEC_STG = 1,
    parameter int RES_STG = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSTG-1:0] stage_stall,
    input logic [NSTG-1:0] stage_squash,
    input logic [NSTG-1:0] stage_bubble,
    input logic            fetch_redirect,
    input logic [NSTG-1:0] occ_valid,
    input logic [NSTG-1:0] occ_branch,
    input logic [NSTG-1:0] occ_slot
);
    p_bubble_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_bubble));

    genvar g;
    generate
        for (g = 1; g < NSTG; g++) begin : g_stg
            p_stall_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
                stage_stall[g] |-> stage_stall[g-1]);
            p_bubble_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
                stage_bubble[g] |-> (stage_stall[g-1] && !stage_stall[g]));
        end
        for (g = 0; g < RES_STG; g++) begin : g_young
            p_slot_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (fetch_redirect && occ_slot[g] && !stage_stall[g])
                |=> (occ_slot[g+1] && occ_valid[g+1]));
        end
    endgenerate

    p_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_valid[DEC_STG] && occ_branch[DEC_STG] && (|occ_slot[RES_STG:DEC_STG+1]))
        |-> stage_stall[DEC_STG]);

    p_redirect_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redirect |-> !stage_stall[RES_STG]);

    p_squash_needs_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_redirect |-> (stage_squash == '0));
endmodule

bind slot_hazard_ctrl hzd_checker #(.NSTG(NSTG), .DEC_STG(DEC_STG), .RES_STG(RES_STG)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stage_stall    (stage_stall),
    .stage_squash   (stage_squash),
    .stage_bubble   (stage_bubble),
    .fetch_redirect (fetch_redirect),
    .occ_valid      (occ_valid),
    .occ_branch     (occ_branch),
    .occ_slot       (occ_slot)
);

// File: tb/tb_slot_hazard_ctrl.sv
module tb_slot_hazard_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 7;
    localparam int DEC = 1;
    localparam int RES = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_valid = 1'b0;
    logic         fetch_branch = 1'b0;
    logic [N-1:0] raw_req = '0;
    logic         res_taken = 1'b0;
    logic [N-1:0] stage_stall, stage_squash, stage_bubble;
    logic         fetch_redirect;
    logic [N-1:0] occ_valid, occ_branch, occ_slot;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state and expectations
    logic [N-1:0] mv = '0, mb = '0, md = '0;
    logic         mdue = 1'b0;
    logic [N-1:0] est, ebub, esq;
    logic         efire, eguard, etake, any_mreq;
    bit           pend_r8 = 0;
    logic [31:0]  rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_hazard_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_branch(fetch_branch),
        .raw_req(raw_req), .res_taken(res_taken), .stage_stall(stage_stall),
        .stage_squash(stage_squash), .stage_bubble(stage_bubble),
        .fetch_redirect(fetch_redirect), .occ_valid(occ_valid),
        .occ_branch(occ_branch), .occ_slot(occ_slot)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic model_eval();
        logic [N-1:0] req;
        int h;
        req = raw_req & mv;
        eguard = mv[DEC] & mb[DEC] & (md[2] | md[3] | md[4]);
        req[DEC] = req[DEC] | eguard;
        any_mreq = 1'b0;
        h = 0;
        for (int s = 0; s < N; s++) if (req[s]) begin any_mreq = 1'b1; h = s; end
        for (int s = 0; s < N; s++) begin
            est[s]  = any_mreq && (s <= h);
            ebub[s] = any_mreq && (s == h + 1);
        end
        efire = mv[RES] & mb[RES] & res_taken & ~est[RES];
        for (int s = 0; s < N; s++) esq[s] = efire && (s < RES) && mv[s] && !md[s];
        etake = !est[0] && fetch_valid && !(efire && !mdue);
    endtask

    task automatic model_step();
        logic [N-1:0] nv, nb, nd;
        for (int s = 1; s < N; s++) begin
            if (est[s]) begin
                nv[s] = mv[s] & ~esq[s]; nb[s] = mb[s] & ~esq[s]; nd[s] = md[s];
            end else if (ebub[s]) begin
                nv[s] = 1'b0; nb[s] = 1'b0; nd[s] = 1'b0;
            end else begin
                nv[s] = mv[s-1] & ~esq[s-1]; nb[s] = mb[s-1] & ~esq[s-1]; nd[s] = md[s-1];
            end
        end
        if (est[0]) begin
            nv[0] = mv[0] & ~esq[0]; nb[0] = mb[0] & ~esq[0]; nd[0] = md[0];
        end else begin
            nv[0] = etake; nb[0] = etake & fetch_branch; nd[0] = etake & mdue;
        end
        if (etake) mdue = fetch_branch;
        mv = nv; mb = nb; md = nd;
    endtask

    task automatic compare_cycle();
        model_eval();
        if (pend_r8) chk("R8", "wrong-path fetch discarded", 32'(occ_valid[0]), 32'd0);
        pend_r8 = efire && !mdue && fetch_valid && !est[0];
        chk("R2", "occ_valid",  32'(occ_valid),  32'(mv));
        chk("R2", "occ_branch", 32'(occ_branch), 32'(mb));
        chk("R2", "occ_slot",   32'(occ_slot),   32'(md));
        chk("R3", "stage_stall",  32'(stage_stall),  32'(est));
        chk("R3", "stage_bubble", 32'(stage_bubble), 32'(ebub));
        chk("R6", "fetch_redirect", 32'(fetch_redirect), 32'(efire));
        chk("R7", "stage_squash", 32'(stage_squash), 32'(esq));
        if (eguard) chk("R5", "guard stall at decode", 32'(stage_stall[DEC]), 32'd1);
        if (!any_mreq && raw_req != '0)
            chk("R4", "request from empty stage ignored", 32'(stage_stall), 32'd0);
        if (res_taken && !(mv[RES] && mb[RES]))
            chk("R10", "taken without branch", 32'(fetch_redirect), 32'd0);
        if (res_taken && mv[RES] && mb[RES] && est[RES])
            chk("R9", "redirect held under stall", 32'(fetch_redirect), 32'd0);
        model_step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with idle inputs
        repeat (3) @(negedge clk);
        chk("R1", "occ_valid in reset", 32'(occ_valid), 32'd0);
        chk("R1", "outputs in reset", {7'd0, fetch_redirect, stage_stall, stage_squash, stage_bubble}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "occ after reset", {11'd0, occ_valid, occ_branch, occ_slot}, 32'd0);
        chk("R1", "stall after reset", 32'(stage_stall), 32'd0);
        for (int ph = 0; ph < 5; ph++) begin
            int dens;
            dens = (ph == 0) ? 0 : (ph == 1) ? 1 : (ph == 2) ? 2 : (ph == 3) ? 4 : 3;
            for (int cyc = 0; cyc < 4000; cyc++) begin
                @(negedge clk);
                rng = nxt(rng);
                fetch_valid  = (rng[3:0] < 4'd13);
                fetch_branch = (rng[7:4] < 4'd5) && !mdue;
                res_taken    = rng[8];
                for (int s = 0; s < N; s++) begin
                    rng = nxt(rng);
                    raw_req[s] = (int'(rng[3:0]) < dens);
                end
                #1;
                compare_cycle();
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule